// File: doc/BRIEF.md
# Serial Configuration Loader with Bank Decode

This block is the configuration port that a microcontroller uses to program a radio front end over three wires: a serial clock, a data line and an enable line. The block samples all three lines on its own system clock. It finds the active edge of the serial clock and shifts 16-bit words in, most significant bit first. When the sixteenth bit arrives, the word goes into one of five internal registers. It then stays there until it is overwritten or the block is reset.

The enable level and the top bits of the word together select the target register. With enable low, the two top bits address one of four registers: control, receive divider, reference, and transmit divider. With enable high and the top bit set, the word goes to an auxiliary register. Any change of the enable level restarts the bit count, so a short or broken transfer is dropped and no register changes.

The register contents drive parallel outputs: divider values, the power mode, the mute and volume settings, the clock-output selection and divider, the carrier-detect threshold and the oscillator capacitor select. The block does nothing more with these values.

Top module: `cfg_serial_loader`

## Requirements
- R1: A word is taken in as 16 active serial-clock edges (rising edges by default), most significant bit first. It is written on the sixteenth edge, using the enable level present on that edge.
- R2: With enable low, word bits 15:14 select the target: 00 control, 01 receive divider, 10 reference, 11 transmit divider. The receive and transmit dividers take bits 13:0. The other registers are left unchanged.
- R3: With enable high and bit 15 set, the word goes to the auxiliary register. Bits 14:9 are the capacitor select, 8:5 the carrier-detect threshold, 4:2 the battery threshold and 1:0 the test select.
- R4: A complete word with enable high and bit 15 clear changes no register.
- R5: After reset the outputs are: power mode 11 (inactive), clock divider select 11 (ratio 5), clock output on, all mutes and the battery-detector-off bit clear, volume 0, detector-output select 0, receive divider 7215, transmit divider 9966, reference region 00, reference divider 2048, carrier-detect threshold 1010, and capacitor, battery and test selects 0.
- R6: The control word places its fields as follows: power mode in bits 13:12 (00 receive, 01 active, 10 standby, 11 inactive), battery-detector-off in bit 11, compressor mute in bit 10, expander mute in bit 9, speaker mute in bit 8, volume in bits 7:4, detector-output select in bit 3, clock mute in bit 2 and clock divider select in bits 1:0.
- R7: Clock divider select 00, 01, 10 and 11 gives a divide ratio output of 2, 3, 4 and 5. The clock-on output is the inverse of the clock mute bit.
- R8: The reference word carries the region select in bits 13:12 and the 12-bit reference divider in bits 11:0.
- R9: A change of the enable level drops the bits counted so far. A full word sent after the change is loaded correctly.
- R10: A transfer of fewer than 16 bits that ends with an enable change leaves every register unchanged.
- R11: Words may follow one another with no gap and no enable toggle. Each further group of 16 edges forms a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Enable level: selects the main banks (low) or the auxiliary bank (high) |
| pwr_mode | output | 2 | Power mode field |
| batt_det_off | output | 1 | Battery detector power-off bit |
| comp_mute | output | 1 | Compressor mute |
| exp_mute | output | 1 | Expander mute |
| spk_mute | output | 1 | Speaker mute |
| spk_vol | output | 4 | Speaker volume code |
| det_out_sel | output | 1 | Detector output line select |
| mcu_clk_on | output | 1 | Clock output enabled |
| mcu_div_ratio | output | 3 | Clock output divide ratio (2 to 5) |
| rx_div | output | 14 | Receive divider value |
| tx_div | output | 14 | Transmit divider value |
| ref_div | output | 12 | Reference divider value |
| ref_region | output | 2 | Reference region select |
| lo_cap_sel | output | 6 | Oscillator capacitor select |
| cd_thresh | output | 4 | Carrier-detect threshold code |
| batt_thresh | output | 3 | Battery threshold code |
| test_sel | output | 2 | Test select |

## Verification
If the bit counter is off by one, the word lands shifted and in the wrong bank. The receive or transmit divider then shows a wrong value at the ports within three system clocks of the sixteenth serial edge. If the enable-change clear is lost, a dropped partial transfer joins onto the next word, so a register changes on a short transfer or takes a corrupted value. A decode fault shows at once because a neighbouring register changes while the target keeps its old value. The bench compares all outputs against its own model after every transfer, so each of these faults is visible before the next word starts.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [2:0] {
      BK_CTRL = 3'd0,
      BK_RX   = 3'd1,
      BK_REF  = 3'd2,
      BK_TX   = 3'd3,
      BK_AUX  = 3'd4
   } bank_e;

   localparam int NUM_MAIN  = 4;
   localparam int NUM_BANKS = 5;

   typedef enum logic [1:0] {
      PM_RX       = 2'b00,
      PM_ACTIVE   = 2'b01,
      PM_STANDBY  = 2'b10,
      PM_INACTIVE = 2'b11
   } pwr_mode_e;

   // control word reset: inactive mode, divide-by-5 select, everything else clear
   localparam logic [13:0] CTRL_RST = {PM_INACTIVE, 10'b0, 2'b11};

endpackage

// File: rtl/sl_serial_shift.sv
module sl_serial_shift #(
   parameter int WORD_W    = 16,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_en,
   output logic              commit,
   output logic [WORD_W-1:0] word
);
   localparam int CW = $clog2(WORD_W);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic              sclk_q;
   logic              en_q;
   logic [CW-1:0]     cnt;
   logic [WORD_W-2:0] sr;
   logic              tick;
   logic              en_chg;

   generate
      if (RISE_EDGE) begin : g_rise
         assign tick = ser_clk & ~sclk_q;
      end else begin : g_fall
         assign tick = ~ser_clk & sclk_q;
      end
   endgenerate

   assign en_chg = ser_en ^ en_q;
   assign commit = tick & ~en_chg & (cnt == LAST);
   assign word   = {sr, ser_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         en_q   <= 1'b0;
         cnt    <= '0;
         sr     <= '0;
      end else begin
         sclk_q <= ser_clk;
         en_q   <= ser_en;
         if (tick) begin
            sr <= {sr[WORD_W-3:0], ser_data};
         end
         if (en_chg) begin
            cnt <= tick ? CW'(1) : '0;
         end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/sl_bank_decode.sv
module sl_bank_decode
   import cfg_loader_pkg::*;
(
   input  logic                 commit,
   input  logic                 ser_en,
   input  logic [1:0]           addr,
   output logic [NUM_BANKS-1:0] we
);
   always_comb begin
      we = '0;
      if (commit) begin
         if (!ser_en) begin
            we[addr] = 1'b1;
         end else if (addr[1]) begin
            we[BK_AUX] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sl_word_reg.sv
module sl_word_reg #(
   parameter int           W   = 14,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int          WORD_W    = 16,
   parameter bit          RISE_EDGE = 1'b1,
   parameter int          RX_RST    = 7215,
   parameter int          TX_RST    = 9966,
   parameter int          REF_RST   = 2048,
   parameter logic [3:0]  CD_RST    = 4'b1010
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_clk,
   input  logic        ser_data,
   input  logic        ser_en,
   output logic [1:0]  pwr_mode,
   output logic        batt_det_off,
   output logic        comp_mute,
   output logic        exp_mute,
   output logic        spk_mute,
   output logic [3:0]  spk_vol,
   output logic        det_out_sel,
   output logic        mcu_clk_on,
   output logic [2:0]  mcu_div_ratio,
   output logic [13:0] rx_div,
   output logic [13:0] tx_div,
   output logic [11:0] ref_div,
   output logic [1:0]  ref_region,
   output logic [5:0]  lo_cap_sel,
   output logic [3:0]  cd_thresh,
   output logic [2:0]  batt_thresh,
   output logic [1:0]  test_sel
);
   localparam int DW    = WORD_W - 2;
   localparam int AW    = WORD_W - 1;
   localparam int DIV_W = 14;
   localparam int REF_W = 12;

   localparam logic [DW-1:0] RST_TAB [NUM_MAIN] = '{
      CTRL_RST,
      DW'(RX_RST),
      DW'(REF_RST),
      DW'(TX_RST)
   };
   localparam logic [AW-1:0] AUX_RST = {6'b0, CD_RST, 3'b0, 2'b0};

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("cfg_serial_loader: field layout needs WORD_W == 16");
      end
      if (RX_RST < 16 || RX_RST >= (1 << DIV_W)) begin : g_bad_rx
         $error("cfg_serial_loader: RX_RST out of divider range");
      end
      if (TX_RST < 16 || TX_RST >= (1 << DIV_W)) begin : g_bad_tx
         $error("cfg_serial_loader: TX_RST out of divider range");
      end
      if (REF_RST < 16 || REF_RST >= (1 << REF_W)) begin : g_bad_ref
         $error("cfg_serial_loader: REF_RST out of divider range");
      end
   endgenerate

   logic                 commit;
   logic [WORD_W-1:0]    word;
   logic [NUM_BANKS-1:0] bank_we;
   logic [DW-1:0]        bank_q [NUM_MAIN];
   logic [AW-1:0]        aux_q;
   logic [DW-1:0]        ctrl_q;
   logic [DW-1:0]        ref_q;

   sl_serial_shift #(.WORD_W(WORD_W), .RISE_EDGE(RISE_EDGE)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_en   (ser_en),
      .commit   (commit),
      .word     (word)
   );

   sl_bank_decode u_dec (
      .commit (commit),
      .ser_en (ser_en),
      .addr   (word[WORD_W-1:WORD_W-2]),
      .we     (bank_we)
   );

   generate
      for (genvar b = 0; b < NUM_MAIN; b++) begin : g_bank
         sl_word_reg #(.W(DW), .RST(RST_TAB[b])) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .d     (word[DW-1:0]),
            .q     (bank_q[b])
         );
      end
   endgenerate

   sl_word_reg #(.W(AW), .RST(AUX_RST)) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[BK_AUX]),
      .d     (word[AW-1:0]),
      .q     (aux_q)
   );

   assign ctrl_q = bank_q[BK_CTRL];
   assign ref_q  = bank_q[BK_REF];

   // control fields
   assign pwr_mode      = ctrl_q[13:12];
   assign batt_det_off  = ctrl_q[11];
   assign comp_mute     = ctrl_q[10];
   assign exp_mute      = ctrl_q[9];
   assign spk_mute      = ctrl_q[8];
   assign spk_vol       = ctrl_q[7:4];
   assign det_out_sel   = ctrl_q[3];
   assign mcu_clk_on    = ~ctrl_q[2];
   assign mcu_div_ratio = {1'b0, ctrl_q[1:0]} + 3'd2;

   // divider banks
   assign rx_div     = bank_q[BK_RX];
   assign tx_div     = bank_q[BK_TX];
   assign ref_region = ref_q[13:12];
   assign ref_div    = ref_q[REF_W-1:0];

   // auxiliary fields
   assign lo_cap_sel  = aux_q[14:9];
   assign cd_thresh   = aux_q[8:5];
   assign batt_thresh = aux_q[4:2];
   assign test_sel    = aux_q[1:0];
endmodule

// File: rtl/sl_loader_chk.sv
module sl_loader_chk #(
   parameter bit RISE_EDGE = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ser_clk,
   input logic        ser_en,
   input logic        commit,
   input logic [4:0]  we,
   input logic [1:0]  word_hi,
   input logic [13:0] ctrl_q,
   input logic [13:0] rx_q,
   input logic [14:0] aux_q
);
   logic       m_sclk;
   logic       m_en;
   logic [4:0] m_run;
   logic       m_edge;

   assign m_edge = RISE_EDGE ? (ser_clk && !m_sclk) : (!ser_clk && m_sclk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sclk <= 1'b0;
         m_en   <= 1'b0;
         m_run  <= '0;
      end else begin
         m_sclk <= ser_clk;
         m_en   <= ser_en;
         if (ser_en != m_en)   m_run <= m_edge ? 5'd1 : 5'd0;
         else if (m_edge)      m_run <= (m_run == 5'd15) ? 5'd0 : m_run + 5'd1;
      end
   end

   // R1
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (m_run == 5'd15 && ser_en == m_en && m_edge));

   // R2
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we));

   // R2
   ctrl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> ($past(commit) && !$past(ser_en) && $past(word_hi) == 2'b00));

   // R2
   rx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q != $past(rx_q)) |-> ($past(commit) && !$past(ser_en) && $past(word_hi) == 2'b01));

   // R3
   aux_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_q != $past(aux_q)) |-> ($past(commit) && $past(ser_en) && $past(word_hi[1])));

   // R4
   aux_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && ser_en && !word_hi[1]) |=> ($stable(ctrl_q) && $stable(rx_q) && $stable(aux_q)));
endmodule

bind cfg_serial_loader sl_loader_chk #(.RISE_EDGE(RISE_EDGE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ser_clk (ser_clk),
   .ser_en  (ser_en),
   .commit  (commit),
   .we      (bank_we),
   .word_hi (word[15:14]),
   .ctrl_q  (ctrl_q),
   .rx_q    (rx_div),
   .aux_q   (aux_q)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_en = 1'b0;
   logic [1:0]  pwr_mode;
   logic        batt_det_off, comp_mute, exp_mute, spk_mute, det_out_sel, mcu_clk_on;
   logic [3:0]  spk_vol;
   logic [2:0]  mcu_div_ratio;
   logic [13:0] rx_div, tx_div;
   logic [11:0] ref_div;
   logic [1:0]  ref_region;
   logic [5:0]  lo_cap_sel;
   logic [3:0]  cd_thresh;
   logic [2:0]  batt_thresh;
   logic [1:0]  test_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model of register contents
   logic [13:0] e_ctrl, e_rx, e_ref, e_tx;
   logic [14:0] e_aux;

   always #5 clk = ~clk;

   cfg_serial_loader uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
      .pwr_mode(pwr_mode), .batt_det_off(batt_det_off), .comp_mute(comp_mute),
      .exp_mute(exp_mute), .spk_mute(spk_mute), .spk_vol(spk_vol),
      .det_out_sel(det_out_sel), .mcu_clk_on(mcu_clk_on), .mcu_div_ratio(mcu_div_ratio),
      .rx_div(rx_div), .tx_div(tx_div), .ref_div(ref_div), .ref_region(ref_region),
      .lo_cap_sel(lo_cap_sel), .cd_thresh(cd_thresh), .batt_thresh(batt_thresh),
      .test_sel(test_sel)
   );

   // {enable, word}
   localparam logic [16:0] VEC [10] = '{
      {1'b0, 16'h1AA8},   // control: active, mixed mutes, volume 10
      {1'b0, 16'h44D2},   // rx divider 1234
      {1'b0, 16'hBABC},   // reference region 3, divider 0xABC
      {1'b0, 16'hFFFF},   // tx divider at maximum
      {1'b1, 16'hDADD},   // auxiliary bank
      {1'b1, 16'h7FFF},   // enable high, bit 15 clear: ignored
      {1'b0, 16'h2FF5},   // control: standby, all mutes, clock muted, div 3
      {1'b0, 16'h0002},   // control: rx mode, div 4
      {1'b0, 16'h3083},   // control: inactive, div 5
      {1'b0, 16'h4010}    // rx divider minimum 16
   };

   task automatic chk(string req, string name, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, name, act, exp);
      end
   endtask

   task automatic model_reset();
      e_ctrl = 14'h3003;
      e_rx   = 14'd7215;
      e_tx   = 14'd9966;
      e_ref  = 14'd2048;
      e_aux  = 15'h0140;
   endtask

   task automatic model_write(logic en, logic [15:0] w);
      if (!en) begin
         case (w[15:14])
            2'b00: e_ctrl = w[13:0];
            2'b01: e_rx   = w[13:0];
            2'b10: e_ref  = w[13:0];
            default: e_tx = w[13:0];
         endcase
      end else if (w[15]) begin
         e_aux = w[14:0];
      end
   endtask

   task automatic check_all();
      int ratio;
      case (e_ctrl[1:0])
         2'b00: ratio = 2;
         2'b01: ratio = 3;
         2'b10: ratio = 4;
         default: ratio = 5;
      endcase
      chk("R6", "pwr_mode",      pwr_mode,      e_ctrl[13:12]);
      chk("R6", "batt_det_off",  batt_det_off,  e_ctrl[11]);
      chk("R6", "comp_mute",     comp_mute,     e_ctrl[10]);
      chk("R6", "exp_mute",      exp_mute,      e_ctrl[9]);
      chk("R6", "spk_mute",      spk_mute,      e_ctrl[8]);
      chk("R6", "spk_vol",       spk_vol,       e_ctrl[7:4]);
      chk("R6", "det_out_sel",   det_out_sel,   e_ctrl[3]);
      chk("R7", "mcu_clk_on",    mcu_clk_on,    !e_ctrl[2]);
      chk("R7", "mcu_div_ratio", mcu_div_ratio, ratio);
      chk("R2", "rx_div",        rx_div,        e_rx);
      chk("R2", "tx_div",        tx_div,        e_tx);
      chk("R8", "ref_region",    ref_region,    e_ref[13:12]);
      chk("R8", "ref_div",       ref_div,       e_ref[11:0]);
      chk("R3", "lo_cap_sel",    lo_cap_sel,    e_aux[14:9]);
      chk("R3", "cd_thresh",     cd_thresh,     e_aux[8:5]);
      chk("R3", "batt_thresh",   batt_thresh,   e_aux[4:2]);
      chk("R3", "test_sel",      test_sel,      e_aux[1:0]);
   endtask

   // R1: shift n bits, most significant first, one rising serial edge per bit
   task automatic send_bits(logic en, logic [15:0] w, int n);
      @(negedge clk);
      ser_en = en;
      repeat (3) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         ser_data = w[15-i];
         ser_clk  = 1'b0;
         repeat (2) @(negedge clk);
         ser_clk  = 1'b1;
         repeat (2) @(negedge clk);
      end
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R5: reset values at the ports
      chk("R5", "rst pwr_mode", pwr_mode, 3);
      chk("R5", "rst ratio", mcu_div_ratio, 5);
      chk("R5", "rst rx", rx_div, 7215);
      chk("R5", "rst tx", tx_div, 9966);
      chk("R5", "rst ref", ref_div, 2048);
      chk("R5", "rst cd", cd_thresh, 4'b1010);
      check_all();

      // R1, R2, R3, R4, R11: table of words, back to back with enable held
      for (int v = 0; v < 10; v++) begin
         send_bits(VEC[v][16], VEC[v][15:0], 16);
         model_write(VEC[v][16], VEC[v][15:0]);
         check_all();
      end

      // R9: partial bits, then enable toggles, then a full word
      send_bits(1'b0, 16'h8FFF, 7);
      send_bits(1'b1, 16'h0000, 0);
      send_bits(1'b0, 16'h4321, 16);
      model_write(1'b0, 16'h4321);
      chk("R9", "rx after toggle", rx_div, 14'h0321);
      check_all();

      // R10: short transfer ended by an enable change, no register moves
      send_bits(1'b0, 16'h0000, 9);
      send_bits(1'b1, 16'hFFFF, 5);
      send_bits(1'b0, 16'h0000, 0);
      check_all();

      // R5: reset in the middle of use restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      repeat (2) @(negedge clk);
      check_all();

      finish_run();
   end
endmodule